// File: doc/BRIEF.md
# Four-Entry Shifting FIFO Controller

The block is a first-in first-out queue that holds four words. Each accepted write places the new word in a fixed tail register. Every entry already held moves one register deeper in the same clock edge. The oldest word reaches the output through a four-way multiplexer whose select follows the number of stored entries.

A small Mealy controller keeps count of the stored entries and drives the datapath. It raises the write enable for the shift registers and sets the head select. It also asserts a combinational error flag when a request is illegal:

- a write while the queue is full,
- a delete while the queue is empty,
- a write and a delete in the same cycle.

An illegal request leaves the queue exactly as it was. Data width is a parameter.

Top module: `shfifo_top`

## Requirements
- R1: While `rst_ni` is low, the queue is empty and all four storage registers clear to zero, so `data_o` reads zero. With no request pending after reset, `err_o` is low.
- R2: A legal write (`wr_i`=1, `del_i`=0, queue not full) loads `data_i` into the tail register R0 at the clock edge. In the same edge R0 moves to R1, R1 to R2 and R2 to R3, and the entry count rises by one.
- R3: `data_o` shows register R[count-1], which is always the oldest stored word. Words leave in the order they were written.
- R4: A legal delete (`del_i`=1, `wr_i`=0, queue not empty) drops the head and lowers the count by one. The next-oldest word appears on `data_o` after the edge.
- R5: A write while four entries are held raises `err_o` in that same cycle. Neither the count nor the contents change.
- R6: A delete while the queue is empty raises `err_o` in that same cycle, and the count stays at zero.
- R7: `wr_i` and `del_i` high together raise `err_o` at any count, and the queue is left unchanged.
- R8: `err_o` is combinational from the current count and the requests. It is low in any cycle with no request or with a legal request.
- R9: With the queue empty the head select is 0, so `data_o` shows the value held in R0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write request |
| del_i | input | 1 | Delete request for the head entry |
| data_i | input | DATA_W | Word to enqueue |
| data_o | output | DATA_W | Oldest stored word |
| err_o | output | 1 | Illegal request in the current cycle |

## Verification
The hardest situation to reach is a simultaneous write and delete at an intermediate count. The queue must first be filled partway and then drained partway, so that a wrong state or shift would show as the wrong word at the head. The stimulus table brings the queue to two entries, and later back to three entries after draining from full, and issues the paired request at each point. The head word is then checked to be unchanged. Overflow is reached by four legal writes followed by a fifth. A reset applied while the queue is occupied is tested separately, to show that the queue empties and that a following delete is flagged.

// File: rtl/shfifo_pkg.sv
package shfifo_pkg;
  typedef enum logic [2:0] {
    OCC_0 = 3'b000,
    OCC_1 = 3'b001,
    OCC_2 = 3'b010,
    OCC_3 = 3'b011,
    OCC_4 = 3'b100
  } occ_e;
endpackage

// File: rtl/shfifo_ctrl.sv
module shfifo_ctrl
  import shfifo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       del_i,
  output logic       wr_en_o,
  output logic [1:0] sel_o,
  output logic       err_o
);
  occ_e state_q, state_d;
  logic full, empty;

  always_comb begin
    full    = (state_q == OCC_4);
    empty   = (state_q == OCC_0);
    err_o   = (wr_i && del_i) || (wr_i && full) || (del_i && empty);
    wr_en_o = wr_i && !del_i && !full;
    sel_o   = empty ? 2'd0 : 2'(state_q - 3'd1);
    state_d = state_q;
    case (state_q)
      OCC_0: if (wr_en_o) state_d = OCC_1;
      OCC_1: if (wr_en_o) state_d = OCC_2; else if (del_i && !err_o) state_d = OCC_0;
      OCC_2: if (wr_en_o) state_d = OCC_3; else if (del_i && !err_o) state_d = OCC_1;
      OCC_3: if (wr_en_o) state_d = OCC_4; else if (del_i && !err_o) state_d = OCC_2;
      OCC_4: if (del_i && !err_o) state_d = OCC_3;
      default: state_d = OCC_0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= OCC_0;
    else         state_q <= state_d;
  end

  AST_ERR_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> $stable(state_q)); // R7
  AST_WR_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> (state_q == occ_e'(3'($past(state_q) + 3'd1)))); // R2
  AST_DEL_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (del_i && !wr_i && state_q != OCC_0) |=> (state_q == occ_e'(3'($past(state_q) - 3'd1)))); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && state_q == OCC_4) |-> (err_o && !wr_en_o)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (del_i && state_q == OCC_0) |=> (state_q == OCC_0)); // R6
  AST_OCC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q <= OCC_4); // R3
endmodule

// File: rtl/shfifo_regs.sv
module shfifo_regs #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         shift_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [DEPTH-1:0][DATA_W-1:0] regs_o
);
  logic [DEPTH-1:0][DATA_W-1:0] regs_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [DATA_W-1:0] nxt;
    if (i == 0) begin : g_tail
      assign nxt = data_i;
    end else begin : g_body
      assign nxt = regs_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      regs_q[i] <= '0;
      else if (shift_i) regs_q[i] <= nxt;
    end
  end

  assign regs_o = regs_q;

  AST_TAIL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (regs_q[0] == $past(data_i))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(regs_q)); // R5
endmodule

// File: rtl/shfifo_mux.sv
module shfifo_mux #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] regs_i,
  input  logic [SEL_W-1:0]             sel_i,
  output logic [DATA_W-1:0]            data_o
);
  always_comb begin
    data_o = regs_i[0];
    for (int i = 0; i < DEPTH; i++)
      if (sel_i == SEL_W'(i)) data_o = regs_i[i];
  end
endmodule

// File: rtl/shfifo_top.sv
module shfifo_top #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              del_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  localparam int DEPTH = 4;
  localparam int SEL_W = $clog2(DEPTH);

  logic                         wr_en;
  logic [SEL_W-1:0]             sel;
  logic [DEPTH-1:0][DATA_W-1:0] regs;

  shfifo_ctrl u_ctrl (
    .clk_i, .rst_ni, .wr_i, .del_i,
    .wr_en_o(wr_en), .sel_o(sel), .err_o
  );

  shfifo_regs #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_regs (
    .clk_i, .rst_ni, .shift_i(wr_en), .data_i, .regs_o(regs)
  );

  shfifo_mux #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mux (
    .regs_i(regs), .sel_i(sel), .data_o
  );

  AST_ERR_BLOCKS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !wr_en); // R5
  AST_ERR_KEEPS_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> $stable(data_o)); // R7
endmodule

// File: tb/sim_shfifo_top.sv
module sim_shfifo_top;
  localparam int W = 8;
  localparam int NV = 17;

  typedef struct packed {
    logic         wr;
    logic         del;
    logic [W-1:0] din;
    logic         err;
    logic [W-1:0] dout;
    logic [3:0]   req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'h00, 1'b1, 8'h00, 4'd6}, // R6 delete while empty
    '{1'b1, 1'b0, 8'hA1, 1'b0, 8'hA1, 4'd2}, // R2 first write
    '{1'b1, 1'b0, 8'hB2, 1'b0, 8'hA1, 4'd3}, // R3 head stays oldest
    '{1'b1, 1'b1, 8'hC3, 1'b1, 8'hA1, 4'd7}, // R7 paired request at two entries
    '{1'b1, 1'b0, 8'hC3, 1'b0, 8'hA1, 4'd2}, // R2
    '{1'b1, 1'b0, 8'hD4, 1'b0, 8'hA1, 4'd8}, // R8 legal write to full
    '{1'b1, 1'b0, 8'hE5, 1'b1, 8'hA1, 4'd5}, // R5 overflow
    '{1'b0, 1'b1, 8'h00, 1'b0, 8'hB2, 4'd4}, // R4 delete from full
    '{1'b1, 1'b1, 8'h99, 1'b1, 8'hB2, 4'd7}, // R7 paired request at three entries
    '{1'b0, 1'b1, 8'h00, 1'b0, 8'hC3, 4'd4}, // R4
    '{1'b1, 1'b0, 8'h66, 1'b0, 8'hC3, 4'd3}, // R3 write after drain
    '{1'b0, 1'b1, 8'h00, 1'b0, 8'hD4, 4'd4}, // R4
    '{1'b0, 1'b1, 8'h00, 1'b0, 8'h66, 4'd3}, // R3 order preserved
    '{1'b0, 1'b1, 8'h00, 1'b0, 8'h66, 4'd9}, // R9 empty shows R0
    '{1'b0, 1'b1, 8'h00, 1'b1, 8'h66, 4'd6}, // R6
    '{1'b0, 1'b0, 8'h00, 1'b0, 8'h66, 4'd8}, // R8 idle
    '{1'b1, 1'b0, 8'h77, 1'b0, 8'h77, 4'd2}  // R2
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_i = 1'b0;
  logic         del_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] data_o;
  logic         err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  shfifo_top #(.DATA_W(W)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #3;
    check("R1 reset data", 32'(data_o), 32'h0);
    @(negedge clk_i) rst_ni = 1'b1;
    #1 check("R1 idle err", 32'(err_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      wr_i = VECS[i].wr; del_i = VECS[i].del; data_i = VECS[i].din;
      #1 check($sformatf("R%0d err step %0d", VECS[i].req, i), 32'(err_o), 32'(VECS[i].err));
      @(posedge clk_i); #1;
      check($sformatf("R%0d head step %0d", VECS[i].req, i), 32'(data_o), 32'(VECS[i].dout));
    end

    // R1: reset while occupied empties the queue
    @(negedge clk_i);
    wr_i = 1'b0; del_i = 1'b0;
    rst_ni = 1'b0;
    #1 check("R1 async reset data", 32'(data_o), 32'h0);
    @(negedge clk_i) rst_ni = 1'b1;
    del_i = 1'b1;
    #1 check("R1 empty after reset", 32'(err_o), 32'h1);
    @(negedge clk_i) del_i = 1'b0;
    // R9: empty after reset shows the cleared R0
    #1 check("R9 empty head", 32'(data_o), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule